// File: doc/BRIEF.md
# Ethernet Receive Frame FIFO

This block is a byte-wide frame buffer placed between the receive datapath of an Ethernet MAC and a streaming consumer. Every stored byte carries three markers: start of frame, end of frame and error. The buffer compares its fill level with four programmable thresholds. These thresholds throttle the read side near empty, cut off frames near full, send XOFF/XON requests to a separate pause-frame generator, and raise an early data-available signal for the consumer.

The block runs in one of two modes. Programming the data-available threshold to zero selects store-and-forward: a frame becomes readable only after its last byte is stored, and the data-available output stays low. In that mode, frames that carry the error marker can be dropped before any of their bytes reach the read port. Any nonzero value selects cut-through. A single clock drives the whole block, and all state lives in one module.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset the buffer holds no entries. `rd_valid`, `almost_full`, `data_avail`, `xoff_req` and `xon_req` are low and `almost_empty` is high.
- R2: Stored entries leave in write order, carrying the same byte and markers. An entry is removed only in a cycle where `rd_valid` and `rd_ready` are both high. The word layout is `{sop, eop, err, data[7:0]}`.
- R3: `almost_empty` is high exactly when the stored level is at or below `thr_aempty`. In cut-through mode, `rd_valid` is low at or below that level, unless R4 applies.
- R4: In cut-through mode, `rd_valid` stays high below the almost-empty level while at least one stored, unread entry carries an end-of-frame marker. This lets the frame drain completely.
- R5: `almost_full` is high exactly when the number of free entries (256 minus level) is at or below `thr_afull`.
- R6: A byte that arrives mid-frame while `almost_full` is high is stored with both its end and error markers forced high, which closes the frame. All later bytes up to and including the incoming end of frame are dropped. A frame whose first byte arrives while `almost_full` is high is dropped whole. For the closing entry to fit, `thr_afull` must be nonzero.
- R7: `xoff_req` pulses for one cycle when the level first reaches or exceeds a nonzero `thr_secempty`. `xon_req` pulses for one cycle when the level first falls below it. Neither repeats while the level stays on one side of the threshold. A zero threshold disables both.
- R8: In cut-through mode, `data_avail` is high exactly when the level is at or above `thr_secfull`.
- R9: With `thr_secfull` zero, `data_avail` stays low. `rd_valid` is high only while the buffer holds an unread end-of-frame entry that has already been stored.
- R10: In store-and-forward mode with `err_discard` high, a frame that has the error marker on any of its bytes is removed when its end arrives. None of its bytes is ever presented on the read port.
- R11: A write that arrives while all 256 entries are in use is dropped. Stored entries are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Incoming byte valid |
| wr_data | input | 8 | Incoming byte |
| wr_sop | input | 1 | Incoming byte starts a frame |
| wr_eop | input | 1 | Incoming byte ends a frame |
| wr_err | input | 1 | Incoming byte is marked errored |
| err_discard | input | 1 | Drop errored frames in store-and-forward mode |
| thr_aempty | input | 8 | Almost-empty level threshold |
| thr_afull | input | 8 | Almost-full free-entry threshold |
| thr_secempty | input | 8 | Pause XOFF/XON level threshold |
| thr_secfull | input | 8 | Data-available level threshold; zero selects store-and-forward |
| rd_ready | input | 1 | Consumer accepts an entry |
| rd_valid | output | 1 | Head entry may be taken |
| rd_data | output | 8 | Head byte |
| rd_sop | output | 1 | Head entry starts a frame |
| rd_eop | output | 1 | Head entry ends a frame |
| rd_err | output | 1 | Head entry is marked errored |
| almost_empty | output | 1 | Level at or below the almost-empty threshold |
| almost_full | output | 1 | Free entries at or below the almost-full threshold |
| data_avail | output | 1 | Level at or above the data-available threshold |
| xoff_req | output | 1 | One-cycle pause-on request |
| xon_req | output | 1 | One-cycle pause-off request |

## Verification
Writes, reads, commits and rewinds all take effect at the clock edge where they are presented. Every output is a combinational function of the registered state, so the result of a write or read is due at the output one edge later. This includes the one-cycle XOFF/XON pulses, which compare the level after that edge with a flag registered at the same edge. The bench drives inputs at the falling edge and samples all outputs at the next falling edge, before it drives again. After each sample it advances its own model by exactly one edge, so expectation and design always describe the same cycle.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_err,
  input  logic          err_discard,
  input  logic [AW-1:0] thr_aempty,
  input  logic [AW-1:0] thr_afull,
  input  logic [AW-1:0] thr_secempty,
  input  logic [AW-1:0] thr_secfull,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          rd_sop,
  output logic          rd_eop,
  output logic          rd_err,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          data_avail,
  output logic          xoff_req,
  output logic          xon_req
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [10:0] mem [DEPTH];
  logic [AW:0] rptr, wtent, wcom, eop_cnt, level, free;
  logic in_frame, trunc, ferr, sec_q;
  logic sf, full, sec_hi, rd_fire, do_wr, w_eop, w_err, ferr_n, bad;
  logic nxt_trunc, nxt_inf;
  logic [10:0] head;

  assign level = wtent - rptr;
  assign free  = DEPTH_W - level;
  assign sf    = (thr_secfull == '0);
  assign full  = level[AW];
  assign head  = mem[rptr[AW-1:0]];

  assign almost_empty = level <= {1'b0, thr_aempty};
  assign almost_full  = free <= {1'b0, thr_afull};
  assign data_avail   = !sf && (level >= {1'b0, thr_secfull});
  assign sec_hi       = (thr_secempty != '0) && (level >= {1'b0, thr_secempty});
  assign xoff_req     = sec_hi && !sec_q;
  assign xon_req      = !sec_hi && sec_q;

  assign rd_valid = sf ? (eop_cnt != '0)
                       : ((level != '0) && (!almost_empty || eop_cnt != '0));
  assign {rd_sop, rd_eop, rd_err, rd_data} = head;
  assign rd_fire = rd_valid && rd_ready;

  always_comb begin
    do_wr     = 1'b0;
    w_eop     = wr_eop;
    w_err     = wr_err;
    nxt_trunc = trunc;
    nxt_inf   = in_frame;
    if (wr_en) begin
      if (trunc) begin
        if (wr_eop) nxt_trunc = 1'b0;
      end else if (almost_full) begin
        if (in_frame && !full) begin
          do_wr   = 1'b1;
          w_eop   = 1'b1;
          w_err   = 1'b1;
          nxt_inf = 1'b0;
        end
        if (!wr_eop) nxt_trunc = 1'b1;
      end else begin
        do_wr   = 1'b1;
        nxt_inf = !wr_eop;
      end
    end
  end

  assign ferr_n = ferr || w_err;
  assign bad    = w_eop && sf && err_discard && ferr_n;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wtent[AW-1:0]] <= {wr_sop, w_eop, w_err, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr     <= '0;
      wtent    <= '0;
      wcom     <= '0;
      eop_cnt  <= '0;
      in_frame <= 1'b0;
      trunc    <= 1'b0;
      ferr     <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      rptr     <= rptr + (AW+1)'(rd_fire);
      trunc    <= nxt_trunc;
      in_frame <= nxt_inf;
      sec_q    <= sec_hi;
      eop_cnt  <= eop_cnt + (AW+1)'(do_wr && w_eop && !bad)
                          - (AW+1)'(rd_fire && head[9]);
      if (do_wr) begin
        wtent <= bad ? wcom : wtent + 1'b1;
        ferr  <= w_eop ? 1'b0 : ferr_n;
        if (w_eop ? !bad : !sf) wcom <= wtent + 1'b1;
      end
    end
  end
endmodule

module rx_frame_fifo_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [10:0]   rd_word,
  input logic          almost_empty,
  input logic          data_avail,
  input logic          xoff_req,
  input logic          xon_req,
  input logic [AW-1:0] thr_aempty,
  input logic [AW-1:0] thr_secfull,
  input logic [AW:0]   level,
  input logic [AW:0]   eop_cnt
);
  localparam int DEPTH = 1 << AW;

  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  // R2
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid || !$stable(thr_aempty) || !$stable(thr_secfull)));
  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_word));
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xoff_req && xon_req));
  // R7
  xoff_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |=> !xoff_req);
  // R9
  sf_no_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_secfull == '0) |-> !data_avail);
  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_secfull != '0 && almost_empty && rd_valid) |-> (eop_cnt != '0));
endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_word({rd_sop, rd_eop, rd_err, rd_data}), .almost_empty(almost_empty),
  .data_avail(data_avail), .xoff_req(xoff_req), .xon_req(xon_req),
  .thr_aempty(thr_aempty), .thr_secfull(thr_secfull),
  .level(level), .eop_cnt(eop_cnt));

// File: tb/rx_frame_fifo_test.sv
module rx_frame_fifo_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, wr_err = 0, err_discard = 0, rd_ready = 0;
  logic [7:0] wr_data = 0, thr_aempty = 0, thr_afull = 8, thr_secempty = 0, thr_secfull = 16;
  logic rd_valid, rd_sop, rd_eop, rd_err, almost_empty, almost_full, data_avail, xoff_req, xon_req;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_frame_fifo uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err), .err_discard(err_discard),
    .thr_aempty(thr_aempty), .thr_afull(thr_afull), .thr_secempty(thr_secempty),
    .thr_secfull(thr_secfull), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
    .almost_empty(almost_empty), .almost_full(almost_full), .data_avail(data_avail),
    .xoff_req(xoff_req), .xon_req(xon_req));

  logic [10:0] mq[$];
  int ncom, eopc, rem, ntrunc;
  bit m_inf, m_trunc, m_ferr, m_secq;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_sf(); return thr_secfull == 0; endfunction
  function automatic bit m_valid();
    int l = mq.size();
    if (m_sf()) return eopc != 0;
    return l != 0 && (l > thr_aempty || eopc != 0);
  endfunction
  function automatic bit m_sechi();
    return thr_secempty != 0 && mq.size() >= thr_secempty;
  endfunction

  task automatic m_reset();
    mq.delete(); ncom = 0; eopc = 0; rem = 0;
    m_inf = 0; m_trunc = 0; m_ferr = 0; m_secq = 0;
  endtask

  task automatic compare(string dtag);
    int l = mq.size();
    bit ev = m_valid();
    bit sh = m_sechi();
    chk(rd_valid == ev, m_sf() ? "R9" : (l <= thr_aempty ? "R4" : "R3"), rd_valid, ev);
    if (ev && rd_valid)
      chk({rd_sop, rd_eop, rd_err, rd_data} == mq[0], dtag,
          {rd_sop, rd_eop, rd_err, rd_data}, mq[0]);
    chk(almost_empty == (l <= thr_aempty), "R3", almost_empty, l <= thr_aempty);
    chk(almost_full == ((256 - l) <= thr_afull), "R5", almost_full, (256 - l) <= thr_afull);
    chk(data_avail == (!m_sf() && l >= thr_secfull), m_sf() ? "R9" : "R8",
        data_avail, !m_sf() && l >= thr_secfull);
    chk(xoff_req == (sh && !m_secq), "R7", xoff_req, sh && !m_secq);
    chk(xon_req == (!sh && m_secq), "R7", xon_req, !sh && m_secq);
  endtask

  task automatic m_step();
    int l = mq.size();
    bit afull = (256 - l) <= thr_afull;
    bit full = l >= 256;
    bit sh = m_sechi();
    bit fire = m_valid() && rd_ready;
    bit dw = 0, we = wr_eop, wer = wr_err, fn, bad;
    logic [10:0] x;
    if (wr_en) begin
      if (m_trunc) begin
        if (wr_eop) m_trunc = 0;
      end else if (afull) begin
        if (m_inf && !full) begin dw = 1; we = 1; wer = 1; m_inf = 0; ntrunc++; end
        if (!wr_eop) m_trunc = 1;
      end else begin
        dw = 1; m_inf = !wr_eop;
      end
    end
    if (fire) begin
      x = mq.pop_front(); ncom--;
      if (x[9]) eopc--;
    end
    if (dw) begin
      fn = m_ferr || wer;
      bad = we && m_sf() && err_discard && fn;
      mq.push_back({wr_sop, we, wer, wr_data});
      if (we) begin
        if (bad) while (mq.size() > ncom) void'(mq.pop_back());
        else begin ncom = mq.size(); eopc++; end
        m_ferr = 0;
      end else begin
        m_ferr = fn;
        if (!m_sf()) ncom = mq.size();
      end
    end
    m_secq = sh;
  endtask

  task automatic drive(int wprob, int rprob, int maxlen);
    wr_en = ($urandom % 100) < wprob;
    wr_data = 8'($urandom);
    wr_sop = 0; wr_eop = 0; wr_err = 0;
    if (wr_en) begin
      if (rem == 0) begin wr_sop = 1; rem = 1 + ($urandom % maxlen); end
      wr_eop = (rem == 1);
      wr_err = wr_eop ? (($urandom % 4) == 0) : (($urandom % 32) == 0);
      rem--;
    end
    rd_ready = ($urandom % 100) < rprob;
  endtask

  task automatic phase(int ae, int af, int se, int sfl, bit disc, int wprob, int rprob,
                       int maxlen, int ncyc, string dtag);
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_ready = 0;
    thr_aempty = 8'(ae); thr_afull = 8'(af); thr_secempty = 8'(se);
    thr_secfull = 8'(sfl); err_discard = disc;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid && almost_empty && !almost_full && !data_avail && !xoff_req && !xon_req,
        "R1", {rd_valid, almost_empty, almost_full, data_avail, xoff_req, xon_req}, 6'b010000);
    for (int c = 0; c < ncyc + 600; c++) begin
      compare(dtag);
      if (c < ncyc) drive(wprob, rprob, maxlen);
      else begin wr_en = 0; rd_ready = 1; end
      m_step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4099));
    ntrunc = 0;
    m_reset();
    // R2 cut-through, fast reader
    phase(0, 8, 200, 16, 0, 70, 90, 20, 3000, "R2");
    // R6 slow reader forces truncation and pause requests
    phase(6, 12, 120, 40, 0, 80, 25, 40, 3000, "R6");
    chk(ntrunc > 0, "R6", ntrunc, 1);
    // R10 store-and-forward with discard
    phase(3, 10, 150, 0, 1, 60, 45, 24, 3000, "R10");
    // R9 store-and-forward keeping errored frames
    phase(0, 10, 0, 0, 0, 60, 45, 24, 2500, "R9");
    // R11 writes into a full buffer with the reader stopped
    phase(0, 0, 255, 1, 0, 100, 0, 2000, 400, "R11");
    // R4 partial frames held below almost-empty level
    phase(20, 8, 0, 16, 0, 30, 70, 30, 2000, "R4");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule